// File: doc/BRIEF.md
# Serial Wide Modular Adder

This block adds two 440-bit operands and returns their sum modulo 2^440. It is meant to sit next to a multi-cycle hash engine, where latency matters little, so it spends fourteen clock cycles on each addition. This keeps the carry path to a single 32-bit slice. Each cycle adds one slice of the two operands plus a carry bit held in a flip-flop. Slices are taken least significant first, and the last slice is 24 bits wide.

The block holds two operand registers. The accumulator register is loaded from `a_in` and the addend register from `b_in`. Each slice of the sum is written back into the accumulator in place, so no separate result register exists. The accumulator drives `sum_out` at all times. A user starts an addition with a one-cycle `start`, waits for `done`, and reads `sum_out`. If `start` is issued again without reloading, the addend is added once more to the previous result.

Top module: `wide_serial_adder`

## Requirements
- R1: When `done` is high, `sum_out` equals (A + B) mod 2^440, where A and B are the accumulator and addend values when `start` was accepted. The carry out of bit 439 is discarded, so all-ones plus one gives zero.
- R2: `done` goes high exactly 14 rising clock edges after the edge that accepts `start`. `busy` is high for exactly those 14 cycles.
- R3: `done` is high for a single cycle. `busy` falls on the same edge at which `done` rises.
- R4: The sum overwrites the accumulator. A second `start` without a reload returns (previous sum + B) mod 2^440.
- R5: A `start` while `busy` is high is ignored. The running addition ends on its original schedule, with one `done` pulse and the correct sum.
- R6: `load_a` and `load_b` while `busy` is high are ignored. The running addition's result is unchanged, and the next addition still uses the old addend.
- R7: After reset, `busy` and `done` are low and both operand registers hold zero, so `sum_out` reads zero.
- R8: The carry ripples from slice to slice in order of significance. A carry that starts in bit 0 can travel through every slice up to bit 439. For example, 2^32-1 plus 1 gives 2^32, and (2^439 - 1) plus 1 gives 2^439.
- R9: While idle, `sum_out` holds its value unless `load_a` is high. `start` and `load_a` in the same idle cycle load the accumulator first, and the addition then uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an addition; accepted only while idle |
| load_a | input | 1 | Load the accumulator from `a_in` while idle |
| load_b | input | 1 | Load the addend from `b_in` while idle |
| a_in | input | 440 | Accumulator operand |
| b_in | input | 440 | Addend operand |
| busy | output | 1 | Addition in progress |
| done | output | 1 | One-cycle pulse when the sum is complete |
| sum_out | output | 440 | Accumulator contents; the sum once `done` is seen |

## Verification
A wrong slice index or a stuck carry flip-flop corrupts exactly the bits of the slice it touches. This shows at `sum_out` in the cycle `done` rises, so the vectors place carries at slice boundaries and at the 24-bit top slice. A control fault, such as a restart on a busy `start`, moves the `done` edge away from the 14th cycle or produces a second pulse. The checker catches this within one cycle, and the bench catches it through its own latency count. Addend corruption during a run appears only on the next chained addition, so R6 is checked across two consecutive starts.

// File: rtl/wsa_pkg.sv
package wsa_pkg;
    localparam int unsigned DEF_SUM_W   = 440;
    localparam int unsigned DEF_SLICE_W = 32;

    function automatic int unsigned slice_count(input int unsigned sum_w, input int unsigned slice_w);
        return (sum_w + slice_w - 1) / slice_w;
    endfunction
endpackage

// File: rtl/wsa_slice.sv
module wsa_slice #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic [W-1:0] keep,
    output logic [W-1:0] s,
    output logic         cout
);
    logic [W:0] full;

    always_comb begin
        full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        s    = full[W-1:0] & keep;
        cout = full[W];
    end
endmodule

// File: rtl/wsa_seq.sv
module wsa_seq #(
    parameter int unsigned NSL   = 14,
    parameter int unsigned IDX_W = (NSL > 1) ? $clog2(NSL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             accept,
    output logic             last,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSL - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        accept     = start && !seq_q.busy;
        last       = seq_q.busy && (seq_q.idx == LAST_IDX);
        if (accept) begin
            seq_d.busy = 1'b1;
            seq_d.idx  = '0;
        end else if (last) begin
            seq_d.busy = 1'b0;
            seq_d.done = 1'b1;
            seq_d.idx  = '0;
        end else if (seq_q.busy) begin
            seq_d.idx = seq_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy = seq_q.busy;
    assign done = seq_q.done;
    assign idx  = seq_q.idx;
endmodule

// File: rtl/wide_serial_adder.sv
module wide_serial_adder #(
    parameter int unsigned SUM_W   = wsa_pkg::DEF_SUM_W,
    parameter int unsigned SLICE_W = wsa_pkg::DEF_SLICE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             load_a,
    input  logic             load_b,
    input  logic [SUM_W-1:0] a_in,
    input  logic [SUM_W-1:0] b_in,
    output logic             busy,
    output logic             done,
    output logic [SUM_W-1:0] sum_out
);
    localparam int unsigned NSL       = wsa_pkg::slice_count(SUM_W, SLICE_W);
    localparam int unsigned IDX_W     = (NSL > 1) ? $clog2(NSL) : 1;
    localparam int unsigned PAD_W     = NSL * SLICE_W;
    localparam int unsigned LAST_BITS = SUM_W - (NSL - 1) * SLICE_W;
    localparam logic [SLICE_W-1:0] FULL_MASK = {SLICE_W{1'b1}};
    localparam logic [SLICE_W-1:0] LAST_MASK = FULL_MASK >> (SLICE_W - LAST_BITS);

    typedef struct packed {
        logic [PAD_W-1:0] acc;
        logic [PAD_W-1:0] opb;
        logic             carry;
    } dp_t;

    dp_t dp_d, dp_q;

    logic             accept, last, run;
    logic [IDX_W-1:0] idx;
    logic [SLICE_W-1:0] sl_a, sl_b, sl_s, sl_keep;
    logic             sl_cout;
    int unsigned      off;

    wsa_seq #(.NSL(NSL), .IDX_W(IDX_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (run),
        .done  (done),
        .accept(accept),
        .last  (last),
        .idx   (idx)
    );

    always_comb begin
        off     = SLICE_W * int'(idx);
        sl_a    = dp_q.acc[off +: SLICE_W];
        sl_b    = dp_q.opb[off +: SLICE_W];
        sl_keep = last ? LAST_MASK : FULL_MASK;
    end

    wsa_slice #(.W(SLICE_W)) u_slice (
        .a   (sl_a),
        .b   (sl_b),
        .cin (dp_q.carry),
        .keep(sl_keep),
        .s   (sl_s),
        .cout(sl_cout)
    );

    always_comb begin
        dp_d = dp_q;
        if (!run) begin
            if (load_a) dp_d.acc = PAD_W'(a_in);
            if (load_b) dp_d.opb = PAD_W'(b_in);
            if (accept) dp_d.carry = 1'b0;
        end else begin
            dp_d.acc[off +: SLICE_W] = sl_s;
            dp_d.carry               = sl_cout;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign busy    = run;
    assign sum_out = dp_q.acc[SUM_W-1:0];
endmodule

// File: rtl/wsa_chk.sv
module wsa_chk #(
    parameter int unsigned SUM_W = 440,
    parameter int unsigned PAD_W = 448,
    parameter int unsigned LAT   = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             load_a,
    input logic [SUM_W-1:0] sum_out,
    input logic [PAD_W-1:0] opb
);
    localparam int unsigned CNT_W = $clog2(LAT + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (busy) cnt_q <= cnt_q + 1'b1;
        else           cnt_q <= '0;
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt_q == CNT_W'(LAT)));

    assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q < CNT_W'(LAT)));

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_opb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(opb));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load_a && !done) |=> $stable(sum_out));
endmodule

bind wide_serial_adder wsa_chk #(
    .SUM_W(SUM_W),
    .PAD_W(PAD_W),
    .LAT  (NSL)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .load_a (load_a),
    .sum_out(sum_out),
    .opb    (dp_q.opb)
);

// File: tb/wide_serial_adder_bench.sv
module wide_serial_adder_bench;
    localparam int W = 440;
    localparam int NV = 8;
    localparam logic [W-1:0] ONES = {W{1'b1}};
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] VA [NV] = '{
        W'(5),
        ONES,
        ONES,
        {55{8'hAA}},
        W'(64'hFFFF_FFFF),
        ONES >> 1,
        ONE << (W - 1),
        {55{8'h5A}}
    };
    localparam logic [W-1:0] VB [NV] = '{
        W'(7),
        ONE,
        ONES,
        {55{8'h55}},
        ONE,
        ONE,
        ONE << (W - 1),
        {55{8'hC3}}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, load_a = 1'b0, load_b = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic busy, done;
    logic [W-1:0] sum_out;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    wide_serial_adder u_wide_serial_adder (
        .clk(clk), .rst_n(rst_n), .start(start), .load_a(load_a), .load_b(load_b),
        .a_in(a_in), .b_in(b_in), .busy(busy), .done(done), .sum_out(sum_out)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        load_a = 1'b1; load_b = 1'b1; a_in = a; b_in = b;
        @(negedge clk);
        load_a = 1'b0; load_b = 1'b0;
    endtask

    // start pulse, then wait for done; lat counts edges from accepting edge to done
    task automatic run(output int lat, input int poke_at, input logic [W-1:0] poke);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            if (lat == poke_at) begin
                start = 1'b1; load_a = 1'b1; load_b = 1'b1; a_in = poke; b_in = poke;
            end else begin
                start = 1'b0; load_a = 1'b0; load_b = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0; load_a = 1'b0; load_b = 1'b0;
        lat = lat - 1;
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lat;
        logic [W-1:0] prev;
        repeat (3) @(negedge clk);
        // R7: reset state
        chk("R7 busy", W'(busy), '0);
        chk("R7 done", W'(done), '0);
        chk("R7 sum", sum_out, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R8: vector table
        for (int i = 0; i < NV; i++) begin
            load(VA[i], VB[i]);
            run(lat, -1, '0);
            chk("R1 sum", sum_out, VA[i] + VB[i]);
            chk("R2 latency", W'(lat), W'(14));
            @(negedge clk);
            chk("R3 done single", W'(done), '0);
            chk("R3 busy low", W'(busy), '0);
        end
        // R8: explicit carry-chain expectations
        load(W'(64'hFFFF_FFFF), ONE);
        run(lat, -1, '0);
        chk("R8 slice carry", sum_out, W'(65'h1_0000_0000));
        load(ONES >> 1, ONE);
        run(lat, -1, '0);
        chk("R8 full ripple", sum_out, ONE << (W - 1));
        load(ONES, ONE);
        run(lat, -1, '0);
        chk("R1 wrap to zero", sum_out, '0);

        // R4: chained addition reuses result as operand
        load(W'(1000), W'(234));
        run(lat, -1, '0);
        run(lat, -1, '0);
        chk("R4 chained", sum_out, W'(1468));

        // R5 R6: start and loads mid-run ignored
        load({55{8'h3C}}, {55{8'h96}});
        run(lat, 5, ONES);
        chk("R5 latency", W'(lat), W'(14));
        chk("R6 sum", sum_out, {55{8'h3C}} + {55{8'h96}});
        @(negedge clk);
        chk("R5 no second done", W'(done), '0);
        chk("R5 idle", W'(busy), '0);
        prev = sum_out;
        run(lat, -1, '0);
        chk("R6 old addend kept", sum_out, prev + {55{8'h96}});

        // R9: idle hold, then load with start in same cycle
        @(negedge clk);
        prev = sum_out;
        a_in = W'(77); b_in = W'(3);
        load_b = 1'b1;
        @(negedge clk);
        load_b = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 hold", sum_out, prev);
        load_a = 1'b1; a_in = W'(40);
        run(lat, -1, '0);
        chk("R9 load+start", sum_out, W'(43));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule